// File: doc/BRIEF.md
# FIFO-Level DMA Request Generator

This block holds a small 8-bit control register and compares the fill level of a byte FIFO against thresholds derived from the FIFO capacity, raising a DMA request line when the selected condition holds. Software programs the register over an address-free synchronous bus with a write strobe, write data and a registered read port.

The register holds a master enable, an auto-transfer flag that is only stored and exported for a downstream sequencer, and a 3-bit condition selector. The selector picks "never", one of three "at or below a fraction of capacity" tests, a "not empty" test, or one of three "at or above a fraction of capacity" tests. The fractions are one quarter, one half and three quarters, and they are computed from the capacity parameter at elaboration.

Top module: `fifo_dreq_gen`

## Requirements
- R1: After reset every register bit reads 0, `dreq` is 0 and `auto_mode` is 0.
- R2: When register bit 7 (enable) is 0, `dreq` is 0 whatever the occupancy and selector.
- R3: Bit 6 is a read/write auto flag driven on `auto_mode`, one cycle after the write.
- R4: Bits 5:3 always read as 0, and writes to them are ignored.
- R5: Selector bits 2:0 = 000 never assert `dreq`.
- R6: Selector 001/010/011 assert `dreq` when `level` <= DEPTH/4, DEPTH/2, 3*DEPTH/4 respectively.
- R7: Selector 100 asserts `dreq` when `level` >= 1.
- R8: Selector 101/110/111 assert `dreq` when `level` >= DEPTH/4, DEPTH/2, 3*DEPTH/4 respectively.
- R9: `dreq` is registered. It reflects the register and `level` as they were at the previous clock edge.
- R10: A read strobe `rd_en` loads `rdata` with the register value on the next clock edge. `rdata` holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Registered read data |
| level | input | LW | FIFO occupancy in bytes, 0..DEPTH |
| dreq | output | 1 | DMA request level |
| auto_mode | output | 1 | Stored auto-transfer flag |

## Verification
On every cycle the assertions check that a cleared enable keeps `dreq` low, that the reserved read bits are zero, that `dreq` matches the selected comparison one cycle later, and that `auto_mode` tracks the last written bit 6. The exact threshold boundaries at each fraction, the reset values and the read timing are shown only by the bench's directed scenarios, which sweep the level across each boundary for every selector.

// File: rtl/fifo_dreq_gen.sv
module fifo_dreq_gen #(
  parameter int DEPTH = 64,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic [LW-1:0] level,
  output logic          dreq,
  output logic          auto_mode
);
  localparam int Q1 = DEPTH / 4;
  localparam int Q2 = DEPTH / 2;
  localparam int Q3 = (3 * DEPTH) / 4;

  logic       en_q;
  logic       auto_q;
  logic [2:0] sel_q;
  logic       hit;
  logic [7:0] regval;

  assign regval    = {en_q, auto_q, 3'b000, sel_q};
  assign auto_mode = auto_q;

  always_comb begin
    case (sel_q)
      3'd1:    hit = 32'(level) <= Q1;
      3'd2:    hit = 32'(level) <= Q2;
      3'd3:    hit = 32'(level) <= Q3;
      3'd4:    hit = level != '0;
      3'd5:    hit = 32'(level) >= Q1;
      3'd6:    hit = 32'(level) >= Q2;
      3'd7:    hit = 32'(level) >= Q3;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      sel_q  <= 3'd0;
      dreq   <= 1'b0;
      rdata  <= 8'd0;
    end else begin
      if (wr_en) begin
        en_q   <= wdata[7];
        auto_q <= wdata[6];
        sel_q  <= wdata[2:0];
      end
      if (rd_en) rdata <= regval;
      dreq <= en_q & hit;
    end
  end
endmodule

// File: rtl/fifo_dreq_gen_chk.sv
module fifo_dreq_gen_chk #(
  parameter int DEPTH = 64,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic          rd_en,
  input logic [7:0]    rdata,
  input logic [LW-1:0] level,
  input logic          dreq,
  input logic          auto_mode
);
  logic       seen;
  logic [7:0] shadow;
  logic       expq;
  logic [31:0] lv;
  assign lv = 32'(level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      shadow <= 8'd0;
    end else begin
      seen <= 1'b1;
      if (wr_en) shadow <= {wdata[7:6], 3'b000, wdata[2:0]};
    end
  end

  always_comb begin
    case (shadow[2:0])
      3'd1: expq = lv <= DEPTH / 4;
      3'd2: expq = lv <= DEPTH / 2;
      3'd3: expq = lv <= (3 * DEPTH) / 4;
      3'd4: expq = lv >= 1;
      3'd5: expq = lv >= DEPTH / 4;
      3'd6: expq = lv >= DEPTH / 2;
      3'd7: expq = lv >= (3 * DEPTH) / 4;
      default: expq = 1'b0;
    endcase
  end

  // R2
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !shadow[7] && !wr_en) |=> !dreq);
  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[5:3] == 3'b000);
  // R9
  dreq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> dreq == $past(shadow[7] & expq));
  // R3
  auto_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> auto_mode == shadow[6]);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rd_en) |=> $stable(rdata));
endmodule

bind fifo_dreq_gen fifo_dreq_gen_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/sim_fifo_dreq_gen.sv
module sim_fifo_dreq_gen;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [LW-1:0] level = 0;
  logic dreq, auto_mode;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_dreq_gen #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  function automatic bit model(logic [2:0] s, int l);
    case (s)
      3'd1: return l <= DEPTH / 4;
      3'd2: return l <= DEPTH / 2;
      3'd3: return l <= 3 * DEPTH / 4;
      3'd4: return l >= 1;
      3'd5: return l >= DEPTH / 4;
      3'd6: return l >= DEPTH / 2;
      3'd7: return l >= 3 * DEPTH / 4;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 dreq", {7'd0, dreq}, 0);
    chk("R1 auto", {7'd0, auto_mode}, 0);
    rd(v); chk("R1 reg", v, 0);
  endtask

  task automatic sweep(logic [2:0] s, bit en, string req);
    int pts[9] = '{0, 1, 15, 16, 17, 32, 33, 47, 48};
    wr({en, 1'b0, 3'b000, s});
    foreach (pts[i]) begin
      @(negedge clk); level = LW'(pts[i]);
      @(negedge clk);
      chk(req, {7'd0, dreq}, {7'd0, en & model(s, pts[i])});
    end
    @(negedge clk); level = LW'(DEPTH); @(negedge clk);
    chk(req, {7'd0, dreq}, {7'd0, en & model(s, DEPTH)});
  endtask

  task automatic t_auto_rsvd();
    logic [7:0] v;
    wr(8'h7F);
    chk("R3 auto", {7'd0, auto_mode}, 1);
    rd(v); chk("R4 rsvd", v, 8'h47);
    wr(8'hB8);
    chk("R3 auto clr", {7'd0, auto_mode}, 0);
    rd(v); chk("R4 rsvd2", v, 8'h80);
  endtask

  task automatic t_timing();
    logic [7:0] v;
    wr(8'h84); level = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 low", {7'd0, dreq}, 0);
    level = 5;
    @(posedge clk); #1;
    chk("R9 one edge", {7'd0, dreq}, 1);
    wr(8'h04);
    @(negedge clk);
    chk("R2 disable", {7'd0, dreq}, 0);
    @(negedge clk); rd_en = 1; @(posedge clk); #1;
    chk("R10 one edge", rdata, 8'h04);
    rd_en = 0;
    wr(8'hC5); @(negedge clk);
    chk("R10 hold", rdata, 8'h04);
    rd(v); chk("R10 new", v, 8'hC5);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    sweep(3'd0, 1, "R5");
    sweep(3'd1, 1, "R6 q1");
    sweep(3'd2, 1, "R6 q2");
    sweep(3'd3, 1, "R6 q3");
    sweep(3'd4, 1, "R7");
    sweep(3'd5, 1, "R8 q1");
    sweep(3'd6, 1, "R8 q2");
    sweep(3'd7, 1, "R8 q3");
    sweep(3'd4, 0, "R2");
    sweep(3'd6, 0, "R2");
    t_auto_rsvd();
    t_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule